// File: doc/BRIEF.md
# Clock Loop Operating Mode Controller

This block supervises one digital clock-synthesis loop. It keeps track of the loop's operating mode: free-run, acquisition, locked or holdover. Its inputs are the input-qualification flags, the current input selection, the phase-lock indicator, a flag saying whether the averaged frequency history is usable, and a few configuration controls. When the selected input fails, the block decides between three actions: switch to another qualified input, freeze into holdover, or fall back to free-run.

The block also picks the loop bandwidth. It chooses between a normal setting and a temporary wide setting used while lock is missing. Both settings are held in shadow registers that change only on an explicit update strobe.

Software can force the loop into holdover. When automatic exit is turned off, every entry into holdover sets that force bit, and the loop stays in holdover until software clears it.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00, `switch_req_o`, `freeze_o` and `force_hold_o` are 0, and both stored bandwidth words are 0. The mode code is 00 for free-run, 01 for acquisition, 10 for locked and 11 for holdover.
- R2: In free-run, if the selected input (`in_valid_i[in_sel_i]`) is valid at a clock edge, `mode_o` becomes 01 after that edge.
- R3: Acquisition moves to locked at the first edge where `lock_i` is 1 and the selected input is valid. Locked returns to acquisition when `lock_i` falls while the selected input is still valid.
- R4: In acquisition or locked, if the selected input becomes invalid while another input is valid, then for one cycle after that edge `mode_o` is 01, `switch_req_o` is 1, and `switch_sel_o` gives the lowest-numbered other valid input.
- R5: If the selected input fails and no other input is valid, the mode becomes holdover (11) with a one-cycle `freeze_o` pulse when `hist_valid_i` is 1. Otherwise the mode becomes free-run (00) with no freeze pulse.
- R6: `fast_bw_o` equals `manual_fl_i | (auto_fl_en_i & ~lock_i)`, so automatic wide bandwidth has no effect while the manual control is 1. `bw_active_o` shows the stored wide word when `fast_bw_o` is 1 and the stored normal word otherwise.
- R7: The stored bandwidth words load from `bw_norm_cfg_i` and `bw_fast_cfg_i` only on an edge where `bw_update_i` is 1. `soft_rst_i` returns the mode to free-run and leaves both stored words unchanged.
- R8: A pulse on `force_set_i` sets `force_hold_o` at the next edge. On the edge after that, a free-run or locked loop enters holdover with a freeze pulse, and it stays in holdover while `force_hold_o` is 1, whatever the inputs are.
- R9: Holdover exits to acquisition at the first edge where `force_hold_o` is 0 and at least one input is valid. If the selected input is not valid, a switch request to the lowest valid input goes with that exit.
- R10: When `auto_exit_i` is 0, entering holdover sets `force_hold_o`. This set wins over a `force_clr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_IN | Qualification flag per input |
| in_sel_i | input | SEL_W | Currently selected input |
| lock_i | input | 1 | Phase lock achieved (low = loss of lock) |
| hist_valid_i | input | 1 | Averaged frequency history usable |
| auto_fl_en_i | input | 1 | Enable automatic wide bandwidth |
| manual_fl_i | input | 1 | Manual wide bandwidth control |
| auto_exit_i | input | 1 | Automatic holdover exit enable |
| force_set_i | input | 1 | Software set of the force-hold bit |
| force_clr_i | input | 1 | Software clear of the force-hold bit |
| bw_update_i | input | 1 | Load strobe for the bandwidth words |
| soft_rst_i | input | 1 | Soft reset of the mode state |
| bw_norm_cfg_i | input | BW_W | Pending normal bandwidth word |
| bw_fast_cfg_i | input | BW_W | Pending wide bandwidth word |
| mode_o | output | 2 | Current mode code |
| switch_req_o | output | 1 | One-cycle input switch request |
| switch_sel_o | output | SEL_W | Target input of the switch request |
| freeze_o | output | 1 | One-cycle pulse on holdover entry |
| force_hold_o | output | 1 | Force-hold bit |
| fast_bw_o | output | 1 | Wide bandwidth selected |
| bw_active_o | output | BW_W | Bandwidth word in use |

## Verification
The delicate coincidence is a holdover entry with automatic exit off landing on the same edge as a software clear of the force bit. The bench sets this up by dropping the only valid input of a locked loop with history valid, while `force_clr_i` is high in that same cycle. It then expects `force_hold_o` to read 1 and the mode to read holdover.

A second overlap comes from a forced holdover that meets valid inputs with automatic exit on. In that case the mode must stay in holdover until the clear arrives.

All selected-input and valid-input mask combinations are swept, and the expected switch target is computed as the lowest set bit of the mask.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_ACQ  = 2'b01,
    MODE_LOCK = 2'b10,
    MODE_HOLD = 2'b11
  } mode_t;
endpackage

// File: rtl/pll_input_pick.sv
module pll_input_pick #(
  parameter int N_IN  = 4,
  parameter int SEL_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  valid_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cur_ok_o,
  output logic             any_o,
  output logic             other_o,
  output logic [SEL_W-1:0] idx_o
);
  logic [N_IN-1:0] cand;

  for (genvar g = 0; g < N_IN; g++) begin : g_cand
    assign cand[g] = valid_i[g] && (sel_i != SEL_W'(g));
  end

  assign cur_ok_o = valid_i[sel_i];
  assign any_o    = |valid_i;
  assign other_o  = |cand;

  // lowest numbered candidate wins
  always_comb begin
    idx_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = SEL_W'(i);
    end
  end
endmodule

// File: rtl/pll_bw_bank.sv
module pll_bw_bank #(
  parameter int BW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            update_i,
  input  logic [BW_W-1:0] norm_cfg_i,
  input  logic [BW_W-1:0] fast_cfg_i,
  input  logic            manual_fl_i,
  input  logic            auto_fl_en_i,
  input  logic            lock_i,
  output logic            fast_o,
  output logic [BW_W-1:0] active_o
);
  logic [BW_W-1:0] norm_q, fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_q <= '0;
      fast_q <= '0;
    end else if (update_i) begin
      norm_q <= norm_cfg_i;
      fast_q <= fast_cfg_i;
    end
  end

  // manual control overrides the automatic path
  assign fast_o   = manual_fl_i | (auto_fl_en_i & ~lock_i);
  assign active_o = fast_o ? fast_q : norm_q;

  // R7
  bw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> ($stable(norm_q) && $stable(fast_q)));
  // R6
  bw_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !manual_fl_i) |-> (active_o == norm_q));
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cur_ok_i,
  input  logic             any_i,
  input  logic             other_i,
  input  logic [SEL_W-1:0] pick_i,
  input  logic             lock_i,
  input  logic             hist_valid_i,
  input  logic             auto_exit_i,
  input  logic             force_set_i,
  input  logic             force_clr_i,
  output mode_t            mode_o,
  output logic             switch_o,
  output logic [SEL_W-1:0] switch_sel_o,
  output logic             freeze_o,
  output logic             force_o
);
  mode_t            mode_q, mode_d;
  logic             sw_q, sw_d, frz_q, frz_d, force_q, force_d, ent_set;
  logic [SEL_W-1:0] ssel_q, ssel_d;

  always_comb begin
    mode_d  = mode_q;
    sw_d    = 1'b0;
    ssel_d  = ssel_q;
    frz_d   = 1'b0;
    ent_set = 1'b0;
    if (soft_rst_i) begin
      mode_d = MODE_FREE;
    end else begin
      unique case (mode_q)
        MODE_FREE: begin
          if (force_q) begin
            mode_d = MODE_HOLD;
            frz_d  = 1'b1;
          end else if (cur_ok_i) begin
            mode_d = MODE_ACQ;
          end
        end
        MODE_ACQ, MODE_LOCK: begin
          if (mode_q == MODE_LOCK && force_q) begin
            mode_d = MODE_HOLD;
            frz_d  = 1'b1;
          end else if (!cur_ok_i) begin
            if (other_i) begin
              mode_d = MODE_ACQ;
              sw_d   = 1'b1;
              ssel_d = pick_i;
            end else if (hist_valid_i) begin
              mode_d  = MODE_HOLD;
              frz_d   = 1'b1;
              ent_set = !auto_exit_i;
            end else begin
              mode_d = MODE_FREE;
            end
          end else if (mode_q == MODE_ACQ && lock_i) begin
            mode_d = MODE_LOCK;
          end else if (mode_q == MODE_LOCK && !lock_i) begin
            mode_d = MODE_ACQ;
          end
        end
        MODE_HOLD: begin
          if (!force_q && any_i) begin
            mode_d = MODE_ACQ;
            if (!cur_ok_i) begin
              sw_d   = 1'b1;
              ssel_d = pick_i;
            end
          end
        end
        default: mode_d = MODE_FREE;
      endcase
    end
  end

  // entry set beats a same-cycle software clear
  always_comb begin
    force_d = force_q;
    if (ent_set)          force_d = 1'b1;
    else if (force_clr_i) force_d = 1'b0;
    else if (force_set_i) force_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_FREE;
      sw_q    <= 1'b0;
      ssel_q  <= '0;
      frz_q   <= 1'b0;
      force_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      sw_q    <= sw_d;
      ssel_q  <= ssel_d;
      frz_q   <= frz_d;
      force_q <= force_d;
    end
  end

  assign mode_o       = mode_q;
  assign switch_o     = sw_q;
  assign switch_sel_o = ssel_q;
  assign freeze_o     = frz_q;
  assign force_o      = force_q;

  // R5
  freeze_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_q |-> (mode_q == MODE_HOLD && $past(mode_q) != MODE_HOLD));
  // R3
  lock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOCK && $past(mode_q) == MODE_ACQ) |-> $past(lock_i));
  // R8
  force_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HOLD && force_q && !soft_rst_i) |=> (mode_q == MODE_HOLD));
  // R4
  switch_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_q |-> (mode_q == MODE_ACQ));
  // R10
  entry_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && $past(mode_q) != MODE_FREE && $past(mode_q) != MODE_LOCK && !$past(auto_exit_i))
      |-> force_q);
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int BW_W  = 8,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_valid_i,
  input  logic [SEL_W-1:0] in_sel_i,
  input  logic             lock_i,
  input  logic             hist_valid_i,
  input  logic             auto_fl_en_i,
  input  logic             manual_fl_i,
  input  logic             auto_exit_i,
  input  logic             force_set_i,
  input  logic             force_clr_i,
  input  logic             bw_update_i,
  input  logic             soft_rst_i,
  input  logic [BW_W-1:0]  bw_norm_cfg_i,
  input  logic [BW_W-1:0]  bw_fast_cfg_i,
  output logic [1:0]       mode_o,
  output logic             switch_req_o,
  output logic [SEL_W-1:0] switch_sel_o,
  output logic             freeze_o,
  output logic             force_hold_o,
  output logic             fast_bw_o,
  output logic [BW_W-1:0]  bw_active_o
);
  logic             cur_ok, any_ok, other_ok;
  logic [SEL_W-1:0] pick;
  mode_t            mode;

  pll_input_pick #(.N_IN(N_IN), .SEL_W(SEL_W)) u_pick (
    .valid_i  (in_valid_i),
    .sel_i    (in_sel_i),
    .cur_ok_o (cur_ok),
    .any_o    (any_ok),
    .other_o  (other_ok),
    .idx_o    (pick)
  );

  pll_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .cur_ok_i     (cur_ok),
    .any_i        (any_ok),
    .other_i      (other_ok),
    .pick_i       (pick),
    .lock_i       (lock_i),
    .hist_valid_i (hist_valid_i),
    .auto_exit_i  (auto_exit_i),
    .force_set_i  (force_set_i),
    .force_clr_i  (force_clr_i),
    .mode_o       (mode),
    .switch_o     (switch_req_o),
    .switch_sel_o (switch_sel_o),
    .freeze_o     (freeze_o),
    .force_o      (force_hold_o)
  );

  pll_bw_bank #(.BW_W(BW_W)) u_bw (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .update_i     (bw_update_i),
    .norm_cfg_i   (bw_norm_cfg_i),
    .fast_cfg_i   (bw_fast_cfg_i),
    .manual_fl_i  (manual_fl_i),
    .auto_fl_en_i (auto_fl_en_i),
    .lock_i       (lock_i),
    .fast_o       (fast_bw_o),
    .active_o     (bw_active_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/pll_mode_ctrl_test.sv
module pll_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 4;
  localparam int BW_W = 8;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_IN-1:0]  in_valid = '0;
  logic [SEL_W-1:0] in_sel = '0;
  logic             lock = 1'b0, hist = 1'b0, auto_fl = 1'b0, man_fl = 1'b0;
  logic             auto_exit = 1'b0, f_set = 1'b0, f_clr = 1'b0, bw_upd = 1'b0, srst = 1'b0;
  logic [BW_W-1:0]  norm_cfg = '0, fast_cfg = '0;
  logic [1:0]       mode;
  logic             sw_req, freeze, force_h, fast_bw;
  logic [SEL_W-1:0] sw_sel;
  logic [BW_W-1:0]  bw_act;
  int               n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_mode_ctrl #(.N_IN(N_IN), .BW_W(BW_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sel_i(in_sel),
    .lock_i(lock), .hist_valid_i(hist), .auto_fl_en_i(auto_fl), .manual_fl_i(man_fl),
    .auto_exit_i(auto_exit), .force_set_i(f_set), .force_clr_i(f_clr),
    .bw_update_i(bw_upd), .soft_rst_i(srst), .bw_norm_cfg_i(norm_cfg),
    .bw_fast_cfg_i(fast_cfg), .mode_o(mode), .switch_req_o(sw_req),
    .switch_sel_o(sw_sel), .freeze_o(freeze), .force_hold_o(force_h),
    .fast_bw_o(fast_bw), .bw_active_o(bw_act)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic reach_locked(input int s);
    srst = 1'b1; f_clr = 1'b1; in_valid = '0; lock = 1'b0;
    step();
    srst = 1'b0; f_clr = 1'b0;
    in_sel = SEL_W'(s); in_valid = N_IN'(1) << s;
    step();
    lock = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    #1;
    // R1
    chk("R1 mode", mode, 0);
    chk("R1 switch", sw_req, 0);
    chk("R1 freeze", freeze, 0);
    chk("R1 force", force_h, 0);
    chk("R1 bw", bw_act, 0);

    // R2 / R3 basic walk
    in_sel = 2'd1; in_valid = 4'b0010;
    step();
    chk("R2 free->acq", mode, 1);
    step();
    chk("R3 stay acq no lock", mode, 1);
    lock = 1'b1;
    step();
    chk("R3 acq->locked", mode, 2);
    lock = 1'b0;
    step();
    chk("R3 locked->acq on lol", mode, 1);

    // R4 / R5 / R9 / R10 sweep
    for (int s = 0; s < N_IN; s++) begin
      for (int m = 0; m < (1 << N_IN); m++) begin
        if (m[s]) continue;
        for (int h = 0; h < 2; h++) begin
          for (int ae = 0; ae < 2; ae++) begin
            int lo;
            lo = -1;
            for (int j = N_IN - 1; j >= 0; j--) if (m[j]) lo = j;
            reach_locked(s);
            chk("R3 sweep locked", mode, 2);
            hist = h[0]; auto_exit = ae[0];
            in_valid = N_IN'(m); lock = 1'b0;
            step();
            if (lo >= 0) begin
              chk("R4 mode", mode, 1);
              chk("R4 req", sw_req, 1);
              chk("R4 target", sw_sel, lo);
              in_sel = SEL_W'(lo);
              step();
              chk("R4 single pulse", sw_req, 0);
              chk("R4 stays acq", mode, 1);
            end else if (h == 1) begin
              chk("R5 hold", mode, 3);
              chk("R5 freeze", freeze, 1);
              chk("R10 force on entry", force_h, (ae == 0) ? 1 : 0);
              in_valid = N_IN'(1) << s;
              step();
              chk("R5 freeze single", freeze, 0);
              if (ae == 1) begin
                chk("R9 auto exit", mode, 1);
                chk("R9 no switch", sw_req, 0);
              end else begin
                chk("R10 held", mode, 3);
                f_clr = 1'b1;
                step();
                f_clr = 1'b0;
                chk("R10 cleared", force_h, 0);
                step();
                chk("R9 exit after clear", mode, 1);
              end
            end else begin
              chk("R5 free", mode, 0);
              chk("R5 no freeze", freeze, 0);
            end
          end
        end
      end
    end

    // R10 entry set vs same-cycle clear
    reach_locked(0);
    auto_exit = 1'b0; hist = 1'b1; in_valid = '0; f_clr = 1'b1;
    step();
    f_clr = 1'b0;
    chk("R10 set wins mode", mode, 3);
    chk("R10 set wins force", force_h, 1);

    // R9 exit with switch to lowest valid when selected is invalid
    in_valid = 4'b1100;
    f_clr = 1'b1;
    step();
    f_clr = 1'b0;
    step();
    chk("R9 exit mode", mode, 1);
    chk("R9 exit switch", sw_req, 1);
    chk("R9 exit target", sw_sel, 2);

    // R8 force from free-run, held despite valid input and auto exit
    srst = 1'b1; in_valid = '0; auto_exit = 1'b1;
    step();
    srst = 1'b0;
    f_set = 1'b1;
    step();
    f_set = 1'b0;
    chk("R8 force set", force_h, 1);
    chk("R8 still free", mode, 0);
    step();
    chk("R8 free->hold", mode, 3);
    chk("R8 freeze", freeze, 1);
    in_sel = 2'd0; in_valid = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 held", mode, 3);
    end
    f_clr = 1'b1;
    step();
    f_clr = 1'b0;
    chk("R8 cleared hold", mode, 3);
    step();
    chk("R9 exit", mode, 1);

    // R8 force from locked
    reach_locked(2);
    f_set = 1'b1;
    step();
    f_set = 1'b0;
    step();
    chk("R8 locked->hold", mode, 3);
    chk("R8 freeze locked", freeze, 1);
    f_clr = 1'b1;
    step();
    f_clr = 1'b0;

    // R7 bandwidth shadow
    lock = 1'b1; man_fl = 1'b0; auto_fl = 1'b0;
    norm_cfg = 8'd5; fast_cfg = 8'd9; bw_upd = 1'b1;
    step();
    bw_upd = 1'b0;
    chk("R7 load norm", bw_act, 5);
    norm_cfg = 8'd7; fast_cfg = 8'd3;
    step();
    chk("R7 no update", bw_act, 5);
    srst = 1'b1;
    step();
    srst = 1'b0;
    chk("R7 soft rst mode", mode, 0);
    chk("R7 soft rst keeps bw", bw_act, 5);
    man_fl = 1'b1; #1;
    chk("R7 fast kept", bw_act, 9);
    man_fl = 1'b0;
    bw_upd = 1'b1;
    step();
    bw_upd = 1'b0;
    chk("R7 update loads", bw_act, 7);

    // R6 exhaustive fast bandwidth select
    for (int v = 0; v < 8; v++) begin
      int ef;
      man_fl = v[0]; auto_fl = v[1]; lock = v[2];
      #1;
      ef = (v[0] || (v[1] && !v[2])) ? 1 : 0;
      chk("R6 fast", fast_bw, ef);
      chk("R6 active", bw_act, ef ? 3 : 7);
    end

    finish_run();
  end
endmodule